// File: doc/BRIEF.md
# Power-on Jump Controller

After a reset this block takes the processor data bus away from memory and feeds the processor an all-zero byte, which it executes as a no-operation. The processor therefore steps its address forward one fetch at a time. The block watches the top four address bits. When they equal a 4-bit start setting taken from a configuration switch, it hands the data bus back to the normal bus transceivers. The handover lasts until the next reset.

The address lines move through intermediate codes while they change. A raw equality compare can therefore report a short false hit; a step from 9 to A can pass through B. The block never acts on the raw compare. The compare result is taken only when the address-valid strobe is high. It is captured in a synchronizing register on the fast system clock, and it must hold on two consecutive qualified samples before the sticky handover flag sets. Address values between clock edges, and values during strobe-low cycles, have no effect on the flag.

Top module: `por_jump_ctrl`

## Requirements
- R1: While `rst` is high, `nop_drive_en` is 1, `xcvr_en` is 0 and `nop_data` is 8'h00, in the same cycle that `rst` rises, with no clock edge needed.
- R2: `nop_drive_en` is always the inverse of `xcvr_en`, and `nop_data` is 8'h00 whenever `nop_drive_en` is 1.
- R3: A sample is a hit when `addr[15:12]` equals `start_sel[3:0]`. Bits `addr[11:0]` have no influence on the result.
- R4: A clock edge at which `addr_valid` is 0 is not a sample. It neither advances nor clears the run of consecutive hits, whatever the address.
- R5: A single hit sample followed by a sampled miss does not set the flag. Address values that appear between clock edges, such as a transient 9 to B to A, never count as hits.
- R6: Suppose hit samples are taken at clock edges n and n+1, with the run clear before edge n. Then `xcvr_en` is 1 after edge n+2.
- R7: Once `xcvr_en` is 1, it stays 1 for any address, strobe or switch value until `rst` is asserted.
- R8: Reset clears the flag. After `rst` falls, `xcvr_en` stays 0 until a new qualifying run of hits is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Active-high reset |
| addr | input | 16 | Processor address bus |
| start_sel | input | 4 | Start-region setting from the configuration switch |
| addr_valid | input | 1 | High when the address has settled and may be sampled |
| nop_drive_en | output | 1 | Enables the drivers that force the no-op byte onto the data bus |
| nop_data | output | 8 | Forced data byte (no-operation code, 8'h00) |
| xcvr_en | output | 1 | Enables the normal data-bus transceivers |

## Verification
Two events can fall in the same cycle: the second hit sample, which completes the confirming run, and a reset assertion, which must win and leave the outputs in the no-op state. The bench provokes this by raising `rst` between clock edges once the flag is set. It then checks the outputs at once, before any edge, and again after release. Strobe-low cycles that sit inside a run of hits also meet the run counter in the same cycle as a pending hit. They are judged by the exact cycle in which the transceivers turn on.

// File: rtl/por_jump_pkg.sv
package por_jump_pkg;

    localparam int unsigned PJ_SEL_W = 4;

    typedef logic [PJ_SEL_W-1:0] sel_t;

    // One compare result, qualified by the address strobe.
    typedef struct packed {
        logic valid;
        logic hit;
    } sample_t;

    // Handover phase of the sticky flag.
    typedef enum logic [1:0] {
        PH_FEED_NOP = 2'd0,
        PH_HANDED   = 2'd1
    } phase_e;

    function automatic logic sel_equal(input sel_t field, input sel_t setting);
        return field == setting;
    endfunction

endpackage

// File: rtl/pj_addr_compare.sv
module pj_addr_compare
    import por_jump_pkg::*;
(
    input  sel_t    addr_field,
    input  sel_t    start_sel,
    input  logic    addr_valid,
    output sample_t raw
);
    always_comb begin
        raw.valid = addr_valid;
        raw.hit   = sel_equal(addr_field, start_sel);
    end
endmodule

// File: rtl/pj_match_filter.sv
module pj_match_filter
    import por_jump_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 1,
    parameter int unsigned CONFIRM     = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  sample_t raw,
    output logic    confirm
);
    localparam int unsigned CW = $clog2(CONFIRM + 1);

    sample_t        stage [SYNC_STAGES];
    sample_t        synced;
    logic [CW-1:0]  run_cnt;

    // Synchronizer chain: the compare output only reaches the flag
    // logic through clocked registers.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SYNC_STAGES; i++) stage[i] <= '0;
        end else begin
            stage[0] <= raw;
            for (int i = 1; i < SYNC_STAGES; i++) stage[i] <= stage[i-1];
        end
    end

    assign synced = stage[SYNC_STAGES-1];

    // Run of consecutive qualified hits; strobe-low samples hold it.
    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
        end else if (synced.valid) begin
            if (!synced.hit)                run_cnt <= '0;
            else if (run_cnt != CW'(CONFIRM)) run_cnt <= run_cnt + 1'b1;
        end
    end

    assign confirm = synced.valid && synced.hit && (run_cnt >= CW'(CONFIRM - 1));
endmodule

// File: rtl/pj_handover_flag.sv
module pj_handover_flag
    import por_jump_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic confirm,
    output logic nop_drive_en,
    output logic xcvr_en
);
    phase_e phase;

    always_ff @(posedge clk) begin
        if (rst)          phase <= PH_FEED_NOP;
        else if (confirm) phase <= PH_HANDED;
    end

    // Reset overrides the registered phase without waiting for an edge.
    assign xcvr_en      = (phase == PH_HANDED) && !rst;
    assign nop_drive_en = !xcvr_en;
endmodule

// File: rtl/por_jump_ctrl.sv
module por_jump_ctrl
    import por_jump_pkg::*;
#(
    parameter int unsigned ADDR_W      = 16,
    parameter int unsigned DATA_W      = 8,
    parameter logic [7:0]  NOP_CODE    = 8'h00,
    parameter int unsigned SYNC_STAGES = 1,
    parameter int unsigned CONFIRM     = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        start_sel,
    input  logic              addr_valid,
    output logic              nop_drive_en,
    output logic [DATA_W-1:0] nop_data,
    output logic              xcvr_en
);
    localparam int unsigned LOW_W = ADDR_W - PJ_SEL_W;

    sample_t raw;
    logic    confirm;
    logic    unused_low_bits;

    assign unused_low_bits = ^addr[LOW_W-1:0];

    pj_addr_compare u_cmp (
        .addr_field (addr[ADDR_W-1 -: PJ_SEL_W]),
        .start_sel  (start_sel),
        .addr_valid (addr_valid),
        .raw        (raw)
    );

    pj_match_filter #(
        .SYNC_STAGES (SYNC_STAGES),
        .CONFIRM     (CONFIRM)
    ) u_filt (
        .clk     (clk),
        .rst     (rst),
        .raw     (raw),
        .confirm (confirm)
    );

    pj_handover_flag u_flag (
        .clk          (clk),
        .rst          (rst),
        .confirm      (confirm),
        .nop_drive_en (nop_drive_en),
        .xcvr_en      (xcvr_en)
    );

    assign nop_data = DATA_W'(NOP_CODE);
endmodule

// File: rtl/pj_check.sv
module pj_check #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic [3:0]        start_sel,
    input logic              addr_valid,
    input logic              nop_drive_en,
    input logic [DATA_W-1:0] nop_data,
    input logic              xcvr_en
);
    logic qual_hit;
    assign qual_hit = addr_valid && (addr[ADDR_W-1 -: 4] == start_sel);

    // R1: reset forces the no-op state
    always @(posedge clk) begin
        if (rst === 1'b1) begin
            p_reset_drive_r1: assert (nop_drive_en && !xcvr_en && nop_data == '0)
                else $error("reset output state wrong");
        end
    end

    p_exclusive_r2: assert property (@(posedge clk) disable iff (rst)
        (nop_drive_en != xcvr_en) && (!nop_drive_en || nop_data == '0));

    p_rise_needs_hit_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(xcvr_en) |-> $past(qual_hit, 2));

    p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        xcvr_en |=> xcvr_en);

    p_reset_clears_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !xcvr_en);
endmodule

bind por_jump_ctrl pj_check #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pj_check (
    .clk          (clk),
    .rst          (rst),
    .addr         (addr),
    .start_sel    (start_sel),
    .addr_valid   (addr_valid),
    .nop_drive_en (nop_drive_en),
    .nop_data     (nop_data),
    .xcvr_en      (xcvr_en)
);

// File: tb/tb_por_jump_ctrl.sv
module tb_por_jump_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] addr = 16'h0000;
    logic [3:0]  start_sel = 4'hB;
    logic        addr_valid = 1'b0;
    logic        nop_drive_en;
    logic [7:0]  nop_data;
    logic        xcvr_en;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        logic  exp_x;
        string req;
    } exp_item_t;

    exp_item_t sb_q [$];

    always #10 clk = ~clk;

    por_jump_ctrl dut (
        .clk          (clk),
        .rst          (rst),
        .addr         (addr),
        .start_sel    (start_sel),
        .addr_valid   (addr_valid),
        .nop_drive_en (nop_drive_en),
        .nop_data     (nop_data),
        .xcvr_en      (xcvr_en)
    );

    task automatic check_outs(input logic exp_x, input string req);
        n_checks++;
        if (xcvr_en !== exp_x || nop_drive_en !== !exp_x ||
            (!exp_x && nop_data !== 8'h00)) begin
            n_fail++;
            $display("FAIL %s: actual xcvr=%b nop=%b data=%h expected xcvr=%b nop=%b data=00",
                     req, xcvr_en, nop_drive_en, nop_data, exp_x, !exp_x);
        end
    endtask

    // Driver: apply one cycle of stimulus and queue the expected result
    // for the outputs after the next rising edge.
    task automatic drive(input logic [15:0] a, input logic v, input logic exp_x, input string req);
        @(negedge clk);
        addr       = a;
        addr_valid = v;
        sb_q.push_back('{exp_x, req});
    endtask

    // Address walks through a transient code between edges; only the
    // settled value is present at the edge.
    task automatic drive_glitch(input logic [15:0] a_from, input logic [15:0] a_mid,
                                input logic [15:0] a_to, input logic exp_x, input string req);
        @(negedge clk);
        addr       = a_from;
        addr_valid = 1'b1;
        sb_q.push_back('{exp_x, req});
        #3 addr = a_mid;
        #3 addr = a_to;
    endtask

    // Monitor: compare after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                exp_item_t it;
                it = sb_q.pop_front();
                check_outs(it.exp_x, it.req);
            end
        end
    end

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual run still active expected finished");
            finish_up();
        end
    end

    initial begin
        // R1: reset state before and during clocking
        #1 check_outs(1'b0, "R1");
        repeat (3) @(negedge clk);
        check_outs(1'b0, "R1");
        rst = 1'b0;

        // R5 and R3: isolated hits separated by sampled misses
        drive(16'hB123, 1'b1, 1'b0, "R5");
        drive(16'h9123, 1'b1, 1'b0, "R5");
        drive(16'hBFFF, 1'b1, 1'b0, "R5");
        drive(16'h1000, 1'b1, 1'b0, "R3");
        drive(16'hA0B0, 1'b1, 1'b0, "R3");
        drive(16'h0BBB, 1'b1, 1'b0, "R3");

        // R4: matching address with strobe low is never sampled
        for (int i = 0; i < 5; i++) drive(16'hB000 + 16'(i), 1'b0, 1'b0, "R4");

        // R5: transients 9 -> B -> A and A -> B -> 9 between edges
        for (int i = 0; i < 3; i++) begin
            drive_glitch(16'h9FFE, 16'hBFFF, 16'hA000, 1'b0, "R5");
            drive_glitch(16'hA000, 16'hB000, 16'h9FFF, 1'b0, "R5");
        end
        drive(16'h0000, 1'b1, 1'b0, "R5");

        // R4 and R6: strobe-low cycles inside a run do not break it
        drive(16'hB010, 1'b1, 1'b0, "R4");
        drive(16'h2000, 1'b0, 1'b0, "R4");
        drive(16'hB000, 1'b0, 1'b0, "R4");
        drive(16'hB050, 1'b1, 1'b0, "R6");
        drive(16'h3000, 1'b1, 1'b1, "R6");

        // R7: sticky regardless of later inputs
        drive(16'h0000, 1'b1, 1'b1, "R7");
        drive(16'hB000, 1'b0, 1'b1, "R7");
        start_sel = 4'h7;
        drive(16'h1234, 1'b1, 1'b1, "R7");
        drive_glitch(16'h9000, 16'hB000, 16'hA000, 1'b1, "R7");
        drive(16'hFFFF, 1'b0, 1'b1, "R7");
        @(negedge clk);

        // R1 and R8: reset mid-cycle after handover acts at once
        #3 rst = 1'b1;
        #1 check_outs(1'b0, "R1");
        repeat (2) @(negedge clk);
        rst = 1'b0;
        start_sel = 4'hB;
        drive(16'h0000, 1'b1, 1'b0, "R8");
        drive(16'h1000, 1'b1, 1'b0, "R8");
        drive(16'h2000, 1'b1, 1'b0, "R8");

        // R6 and R3: new setting, run with differing low bits
        start_sel = 4'h5;
        drive(16'h5FFF, 1'b1, 1'b0, "R6");
        drive(16'h5000, 1'b1, 1'b0, "R6");
        drive(16'h0000, 1'b0, 1'b1, "R6");
        drive(16'hE000, 1'b1, 1'b1, "R7");
        @(negedge clk);
        @(negedge clk);

        done = 1'b1;
        finish_up();
    end
endmodule